// File: doc/BRIEF.md
# Debug System Bus Access Master

This block gives an external debugger a path into system memory that does not pass through any processor core. The debugger sees five 32-bit registers (one control word, two address halves, two data halves) through a simple register write/read port. From those registers the block issues single-beat read or write transactions of 1, 2, 4 or 8 bytes on a valid/ready request port and collects the answer from a response port.

A write starts when the debugger writes the low data word. A read can start when the low address word is written with the read-on-address option set. Auto-increment advances the address after every successful access by the access size, so a run of data writes streams to consecutive locations. Two sticky error fields record debugger accesses that arrived while a transaction was in flight and transactions that failed or could not be issued. While either is nonzero, no new transaction starts.

Top module: `sba_master`

## Requirements
- R1: After a synchronous active-high reset the control word reads busy=0, both error fields 0, width code 2, auto-increment 0 and read-on-address 0, and the address and data registers read 0. The register selector codes are 0 control, 1 address low, 2 address high, 3 data low, 4 data high. A read returns its value on `dbg_rdata` one cycle after the read request.
- R2: Control word layout: bit 0 busy, bit 1 busy error, bits 4:2 bus error, bits 7:5 width code (access is 2^code bytes), bit 8 auto-increment, bit 9 read-on-address, bits 15:12 size capability (bit 12+k set when 8·2^k bits fit the data width), bits 22:16 the address width in bits; all other bits read 0.
- R3: A write of the low data word while idle and error-free issues a write request with `mem_we`=1, the stored address, `mem_wdata` = {data high, data low} and `mem_size` = width code; busy reads 1 from the next cycle until the cycle after the response.
- R4: A write of the low address word while idle, error-free and with read-on-address set issues a read request; the response data is stored in the data registers by the time busy reads 0.
- R5: A request stays valid with unchanged address, data, direction and size until it is accepted by `mem_req_ready`.
- R6: With auto-increment set, the address advances by 2^width bytes after each access that completes without error; it does not advance after a failed access.
- R7: A write to any address or data register while busy is dropped and sets the busy error bit; that bit stays set until a control write with bit 1 set.
- R8: A response with `mem_rsp_err` sets bus error code 1 (bit 2); each bus error bit clears only through a control write with a 1 in that bit position.
- R9: A start with a width code above the data width's limit issues no request and sets bus error code 2 (bit 3).
- R10: While busy error or bus error is nonzero, data and address writes still load their register but start no transaction.
- R11: Control writes while busy leave width, auto-increment and read-on-address unchanged; their error-clear bits still act.
- R12: A debugger write that falls in the same cycle as the response is still treated as a write during busy.
- R13: Writes of the high data word or the high address word never start a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_valid | input | 1 | Debugger register access this cycle |
| dbg_write | input | 1 | 1 = write, 0 = read |
| dbg_sel | input | 3 | Register selector |
| dbg_wdata | input | 32 | Register write data |
| dbg_rdata | output | 32 | Registered read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 3 | Access size code (2^code bytes) |
| mem_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_err | input | 1 | Response reports a bus error |
| mem_rsp_data | input | DW | Read response data |

## Verification
The sensitive overlap is the completion of a transaction and a debugger register write landing in the same cycle: busy is about to fall, and the write must still be judged as arriving during busy. The bench provokes it by taking over the memory port by hand, accepting the request and then raising the response in exactly the cycle it drives a second low-data write. It then judges that busy has cleared, the busy error bit is set, no second request appears and the low data register still holds the first value.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } sba_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sba_state_e;

  localparam logic [2:0] ERR_BUS  = 3'b001;
  localparam logic [2:0] ERR_SIZE = 3'b010;
  localparam logic [2:0] WIDTH_RST = 3'd2;
endpackage

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_we,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic busy,
  output logic req_valid,
  output logic req_we,
  output logic done
);
  sba_state_e state_q;
  logic       we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_REQ;
          we_q    <= start_we;
        end
        ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign req_we    = we_q;
  assign done      = (state_q == ST_WAIT) && mem_rsp_valid;
endmodule

// File: rtl/sba_ctrl_regs.sv
module sba_ctrl_regs
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [8:0] ctrl_wdata,   // control word bits 9:1
  input  logic       busy,
  input  logic       set_busy_err,
  input  logic [2:0] set_bus_err,
  output logic       busy_err,
  output logic [2:0] bus_err,
  output logic [2:0] cfg_width,
  output logic       cfg_autoinc,
  output logic       cfg_rd_on_addr
);
  logic       clr_busy;
  logic [2:0] clr_bus;

  assign clr_busy = ctrl_wr & ctrl_wdata[0];
  assign clr_bus  = ctrl_wr ? ctrl_wdata[3:1] : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_err       <= 1'b0;
      bus_err        <= 3'b000;
      cfg_width      <= WIDTH_RST;
      cfg_autoinc    <= 1'b0;
      cfg_rd_on_addr <= 1'b0;
    end else begin
      // a new error in the same cycle as a clear wins
      busy_err <= (busy_err & ~clr_busy) | set_busy_err;
      bus_err  <= (bus_err & ~clr_bus) | set_bus_err;
      if (ctrl_wr && !busy) begin
        cfg_width      <= ctrl_wdata[6:4];
        cfg_autoinc    <= ctrl_wdata[7];
        cfg_rd_on_addr <= ctrl_wdata[8];
      end
    end
  end
endmodule

// File: rtl/sba_addr_data.sv
module sba_addr_data
  import sba_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr_lo,
  input  logic          wr_addr_hi,
  input  logic          wr_data_lo,
  input  logic          wr_data_hi,
  input  logic [31:0]   wdata,
  input  logic          incr,
  input  logic [2:0]    width,
  input  logic          load_rd,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic [31:0]   data_hi_word
);
  localparam int AHW = AW - REG_W;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;
  logic [31:0]   data_lo_q;

  assign step = AW'(1) << width;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (wr_addr_lo) begin
      addr_q[31:0] <= wdata;
    end else if (wr_addr_hi) begin
      addr_q[AW-1:32] <= wdata[AHW-1:0];
    end else if (incr) begin
      addr_q <= addr_q + step;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             data_lo_q <= '0;
    else if (wr_data_lo) data_lo_q <= wdata;
    else if (load_rd)    data_lo_q <= rd_data[31:0];
  end

  generate
    if (DW > REG_W) begin : g_hi
      localparam int DHW = DW - REG_W;
      logic [DHW-1:0] data_hi_q;
      always_ff @(posedge clk) begin
        if (rst)             data_hi_q <= '0;
        else if (wr_data_hi) data_hi_q <= wdata[DHW-1:0];
        else if (load_rd)    data_hi_q <= rd_data[DW-1:32];
      end
      assign data         = {data_hi_q, data_lo_q};
      assign data_hi_word = 32'(data_hi_q);
    end else begin : g_no_hi
      assign data         = data_lo_q;
      assign data_hi_word = '0;
    end
  endgenerate

  assign addr = addr_q;
endmodule

// File: rtl/sba_master.sv
module sba_master
  import sba_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_valid,
  input  logic          dbg_write,
  input  logic [2:0]    dbg_sel,
  input  logic [31:0]   dbg_wdata,
  output logic [31:0]   dbg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [DW-1:0] mem_rsp_data
);
  localparam logic [2:0] MAX_WIDTH = 3'($clog2(DW / 8));
  localparam logic [6:0] AW_CODE   = 7'(AW);

  logic       wr, hit_ctrl, hit_alo, hit_ahi, hit_dlo, hit_dhi;
  logic       busy, busy_err, done;
  logic [2:0] bus_err, cfg_width;
  logic       cfg_autoinc, cfg_rd_on_addr;
  logic       want_wr, want_rd, want, errs_clear, size_ok, start;
  logic       set_busy_err;
  logic [2:0] set_bus_err;
  logic       incr, load_rd;
  logic [3:0] cap;
  logic [31:0] ctrl_word, data_hi_word;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;

  // register write decode
  assign wr       = dbg_valid & dbg_write;
  assign hit_ctrl = wr & (dbg_sel == SEL_CTRL);
  assign hit_alo  = wr & (dbg_sel == SEL_ADDR_LO);
  assign hit_ahi  = wr & (dbg_sel == SEL_ADDR_HI);
  assign hit_dlo  = wr & (dbg_sel == SEL_DATA_LO);
  assign hit_dhi  = wr & (dbg_sel == SEL_DATA_HI);

  assign set_busy_err = busy & (hit_alo | hit_ahi | hit_dlo | hit_dhi);

  // start decision
  assign want_wr    = hit_dlo & ~busy;
  assign want_rd    = hit_alo & ~busy & cfg_rd_on_addr;
  assign want       = want_wr | want_rd;
  assign errs_clear = ~busy_err & (bus_err == 3'b000);
  assign size_ok    = (cfg_width <= MAX_WIDTH);
  assign start      = want & errs_clear & size_ok;

  assign incr    = done & ~mem_rsp_err & cfg_autoinc;
  assign load_rd = done & ~mem_rsp_err & ~mem_we;

  always_comb begin
    set_bus_err = 3'b000;
    if (done && mem_rsp_err)                set_bus_err = set_bus_err | ERR_BUS;
    if (want && errs_clear && !size_ok)     set_bus_err = set_bus_err | ERR_SIZE;
  end

  sba_engine u_engine (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_we     (want_wr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .busy         (busy),
    .req_valid    (mem_req_valid),
    .req_we       (mem_we),
    .done         (done)
  );

  sba_ctrl_regs u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .ctrl_wr       (hit_ctrl),
    .ctrl_wdata    (dbg_wdata[9:1]),
    .busy          (busy),
    .set_busy_err  (set_busy_err),
    .set_bus_err   (set_bus_err),
    .busy_err      (busy_err),
    .bus_err       (bus_err),
    .cfg_width     (cfg_width),
    .cfg_autoinc   (cfg_autoinc),
    .cfg_rd_on_addr(cfg_rd_on_addr)
  );

  sba_addr_data #(.AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_addr_lo  (hit_alo & ~busy),
    .wr_addr_hi  (hit_ahi & ~busy),
    .wr_data_lo  (hit_dlo & ~busy),
    .wr_data_hi  (hit_dhi & ~busy),
    .wdata       (dbg_wdata),
    .incr        (incr),
    .width       (cfg_width),
    .load_rd     (load_rd),
    .rd_data     (mem_rsp_data),
    .addr        (addr),
    .data        (data),
    .data_hi_word(data_hi_word)
  );

  // size capability: one bit per access size that fits the data width
  generate
    for (genvar k = 0; k < 4; k++) begin : g_cap
      assign cap[k] = ((8 << k) <= DW);
    end
  endgenerate

  always_comb begin
    ctrl_word        = '0;
    ctrl_word[0]     = busy;
    ctrl_word[1]     = busy_err;
    ctrl_word[4:2]   = bus_err;
    ctrl_word[7:5]   = cfg_width;
    ctrl_word[8]     = cfg_autoinc;
    ctrl_word[9]     = cfg_rd_on_addr;
    ctrl_word[15:12] = cap;
    ctrl_word[22:16] = AW_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rdata <= '0;
    end else if (dbg_valid && !dbg_write) begin
      case (dbg_sel)
        SEL_CTRL:    dbg_rdata <= ctrl_word;
        SEL_ADDR_LO: dbg_rdata <= addr[31:0];
        SEL_ADDR_HI: dbg_rdata <= 32'(addr[AW-1:32]);
        SEL_DATA_LO: dbg_rdata <= data[31:0];
        SEL_DATA_HI: dbg_rdata <= data_hi_word;
        default:     dbg_rdata <= '0;
      endcase
    end
  end

  assign mem_addr  = addr;
  assign mem_wdata = data;
  assign mem_size  = cfg_width;
endmodule

// File: rtl/sba_master_chk.sv
module sba_master_chk #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          dbg_valid,
  input logic          dbg_write,
  input logic [2:0]    dbg_sel,
  input logic [31:0]   dbg_wdata,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [2:0]    mem_size,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_err,
  input logic          busy,
  input logic          busy_err,
  input logic [2:0]    bus_err,
  input logic [2:0]    cfg_width
);
  localparam logic [2:0] MAX_WIDTH = 3'($clog2(DW / 8));

  logic reg_wr, ctrl_clr_busy;
  assign reg_wr        = dbg_valid && dbg_write && (dbg_sel >= 3'd1) && (dbg_sel <= 3'd4);
  assign ctrl_clr_busy = dbg_valid && dbg_write && (dbg_sel == 3'd0) && dbg_wdata[1];

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_we) && $stable(mem_size));

  p_busy_write_flags_r7: assert property (@(posedge clk) disable iff (rst)
    busy && reg_wr |=> busy_err);

  p_busy_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    busy_err && !ctrl_clr_busy |=> busy_err);

  p_bus_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_req_valid && mem_rsp_valid && mem_rsp_err |=> bus_err[0]);

  p_no_req_bad_size_r9: assert property (@(posedge clk) disable iff (rst)
    !busy && (cfg_width > MAX_WIDTH) |=> !mem_req_valid);

  p_no_start_on_err_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && (busy_err || bus_err != 3'b000) |=> !busy);

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_width));
endmodule

bind sba_master sba_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dbg_valid    (dbg_valid),
  .dbg_write    (dbg_write),
  .dbg_sel      (dbg_sel),
  .dbg_wdata    (dbg_wdata),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_size     (mem_size),
  .mem_wdata    (mem_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_err  (mem_rsp_err),
  .busy         (busy),
  .busy_err     (busy_err),
  .bus_err      (bus_err),
  .cfg_width    (cfg_width)
);

// File: tb/test_sba_master.sv
`timescale 1ns/1ps
module test_sba_master;
  localparam int AW = 64;
  localparam int DW = 64;
  localparam logic [2:0] S_CTRL = 3'd0, S_ALO = 3'd1, S_AHI = 3'd2, S_DLO = 3'd3, S_DHI = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [2:0] dbg_sel = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic mem_req_valid, mem_req_ready, mem_we, mem_rsp_valid, mem_rsp_err;
  logic [AW-1:0] mem_addr;
  logic [2:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rsp_data;

  // responder: automatic mode or manual override
  logic resp_en = 1'b1;
  logic a_ready = 1'b0, a_rsp_v = 1'b0, a_rsp_err = 1'b0;
  logic [63:0] a_rsp_data = '0;
  logic m_ready = 1'b0, m_rsp_v = 1'b0;
  assign mem_req_ready = resp_en ? a_ready : m_ready;
  assign mem_rsp_valid = resp_en ? a_rsp_v : m_rsp_v;
  assign mem_rsp_err   = resp_en ? a_rsp_err : 1'b0;
  assign mem_rsp_data  = resp_en ? a_rsp_data : 64'h0;

  int n_chk = 0, n_err = 0;
  int rdy_dly = 0, rsp_dly = 0;
  logic inject_err = 1'b0;
  int cap_n = 0;
  logic [63:0] f_addr, h_addr, f_wdata, h_wdata;
  logic f_we, h_we;
  logic [2:0] f_size, h_size;

  always #2.5 clk = ~clk;

  sba_master #(.AW(AW), .DW(DW)) i_sba_master (
    .clk(clk), .rst(rst), .dbg_valid(dbg_valid), .dbg_write(dbg_write),
    .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data));

  function automatic logic [63:0] pat(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A0F0F, a[63:32] + 32'h01010101};
  endfunction

  function automatic logic [31:0] cfg(input logic [2:0] w, input logic ai, input logic ra);
    return {22'b0, ra, ai, w, 3'b111, 1'b1, 1'b0};
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic b, input logic be, input logic [2:0] bus,
                                           input logic [2:0] w, input logic ai, input logic ra);
    return {9'b0, 7'(AW), 4'hF, 2'b0, ra, ai, w, bus, be, b};
  endfunction

  // automatic responder, acts on falling edges
  initial begin
    int st = 0, cnt = 0;
    forever begin
      @(negedge clk);
      if (!resp_en) st = 0;
      else case (st)
        0: if (mem_req_valid) begin
          f_addr = mem_addr; f_wdata = mem_wdata; f_we = mem_we; f_size = mem_size;
          if (rdy_dly == 0) begin
            h_addr = mem_addr; h_wdata = mem_wdata; h_we = mem_we; h_size = mem_size;
            a_ready = 1'b1; st = 3;
          end else begin cnt = rdy_dly; st = 1; end
        end
        1: begin
          cnt--;
          if (cnt == 0) begin
            h_addr = mem_addr; h_wdata = mem_wdata; h_we = mem_we; h_size = mem_size;
            a_ready = 1'b1; st = 3;
          end
        end
        3: begin
          a_ready = 1'b0; cap_n++;
          a_rsp_err = inject_err; a_rsp_data = h_we ? 64'h0 : pat(h_addr);
          if (rsp_dly == 0) begin a_rsp_v = 1'b1; st = 4; end
          else begin cnt = rsp_dly; st = 2; end
        end
        2: begin cnt--; if (cnt == 0) begin a_rsp_v = 1'b1; st = 4; end end
        4: begin a_rsp_v = 1'b0; a_rsp_err = 1'b0; st = 0; end
        default: st = 0;
      endcase
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = s; dbg_wdata = d;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b0; dbg_sel = s;
    @(negedge clk);
    d = dbg_rdata; dbg_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(S_CTRL, v);
      if (!v[0]) return;
    end
    check({req, " busy never cleared"}, 64'(v[0]), 64'd0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int c0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset state and capability fields
    rd(S_CTRL, v);  check("R1 ctrl reset", 64'(v), 64'(exp_ctrl(0, 0, 3'b0, 3'd2, 0, 0)));
    check("R2 caps and address size", 64'(v[22:12]), 64'({7'd64, 4'hF}));
    rd(S_ALO, v);   check("R1 addr_lo reset", 64'(v), 64'd0);
    rd(S_DHI, v);   check("R1 data_hi reset", 64'(v), 64'd0);

    // R13 high halves do not start; R3 / R5 write with ready delay
    rdy_dly = 3; rsp_dly = 1;
    wr(S_CTRL, cfg(3'd3, 1'b0, 1'b0));
    c0 = cap_n;
    wr(S_AHI, 32'h1); wr(S_ALO, 32'h1000); wr(S_DHI, 32'hDEADBEEF);
    repeat (5) @(negedge clk);
    check("R13 no start from high halves", 64'(cap_n), 64'(c0));
    wr(S_DLO, 32'h12345678);
    rd(S_CTRL, v); check("R3 busy after start", 64'(v[0]), 64'd1);
    wait_idle("R3");
    check("R3 request count", 64'(cap_n), 64'(c0 + 1));
    check("R3 address", h_addr, 64'h1_0000_1000);
    check("R3 data", h_wdata, 64'hDEADBEEF_12345678);
    check("R3 direction and size", {h_we, h_size}, {1'b1, 3'd3});
    check("R5 request stable until ready", {f_addr, f_wdata[31:0]}, {h_addr, h_wdata[31:0]});

    // R4 read on address
    wr(S_CTRL, cfg(3'd2, 1'b0, 1'b1));
    wr(S_AHI, 32'h0); wr(S_ALO, 32'h200);
    wait_idle("R4");
    rd(S_DLO, v); rd(S_DHI, v2);
    check("R4 read data", {v2, v}, pat(64'h200));
    check("R4 read direction", 64'(h_we), 64'd0);

    // R7 / R11 busy error and config hold while busy
    rdy_dly = 8;
    wr(S_CTRL, cfg(3'd3, 1'b0, 1'b0));
    c0 = cap_n;
    wr(S_DLO, 32'h1);
    wr(S_DLO, 32'h2);
    wr(S_CTRL, cfg(3'd0, 1'b1, 1'b0) & ~32'h1E);
    wait_idle("R7");
    rd(S_CTRL, v);
    check("R7 busy error set", 64'(v[1]), 64'd1);
    check("R7 dropped access", 64'(cap_n), 64'(c0 + 1));
    check("R11 config held while busy", 64'(v[8:5]), 64'({1'b0, 3'd3}));
    rd(S_DLO, v); check("R7 dropped data write", 64'(v), 64'd1);
    wr(S_CTRL, cfg(3'd3, 1'b1, 1'b0));
    rd(S_CTRL, v); check("R7 busy error cleared", 64'(v[1]), 64'd0);
    rdy_dly = 0;

    // R8 / R6 / R10 bus error, no increment, blocked start
    wr(S_AHI, 32'h0); wr(S_ALO, 32'h80);
    inject_err = 1'b1;
    wr(S_DLO, 32'hAB);
    wait_idle("R8");
    inject_err = 1'b0;
    rd(S_CTRL, v); check("R8 bus error code 1", 64'(v[4:2]), 64'(3'b001));
    rd(S_ALO, v);  check("R6 no increment after error", 64'(v), 64'h80);
    c0 = cap_n;
    wr(S_DLO, 32'hCD);
    repeat (6) @(negedge clk);
    check("R10 no start with error", 64'(cap_n), 64'(c0));
    rd(S_DLO, v); check("R10 register still loads", 64'(v), 64'hCD);
    wr(S_CTRL, cfg(3'd3, 1'b1, 1'b0) & ~32'h8);
    rd(S_CTRL, v); check("R8 clear only written bit", 64'(v[4:2]), 64'(3'b000));

    // R9 unsupported width
    c0 = cap_n;
    wr(S_CTRL, cfg(3'd5, 1'b0, 1'b0));
    wr(S_DLO, 32'h7);
    repeat (6) @(negedge clk);
    rd(S_CTRL, v);
    check("R9 size error code 2", 64'(v[4:2]), 64'(3'b010));
    check("R9 no request", 64'(cap_n), 64'(c0));
    wr(S_CTRL, cfg(3'd3, 1'b0, 1'b0));
    rd(S_CTRL, v); check("R8 errors cleared", 64'(v[4:1]), 64'd0);

    // R12 debug write in the response cycle, memory port driven by hand
    resp_en = 1'b0;
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = S_DLO; dbg_wdata = 32'hAAAA0001;
    @(negedge clk);
    dbg_valid = 1'b0; dbg_write = 1'b0;
    check("R12 request raised", 64'(mem_req_valid), 64'd1);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0; m_rsp_v = 1'b1;
    dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = S_DLO; dbg_wdata = 32'h5555;
    @(negedge clk);
    m_rsp_v = 1'b0; dbg_valid = 1'b0; dbg_write = 1'b0;
    check("R12 no second request", 64'(mem_req_valid), 64'd0);
    rd(S_CTRL, v);
    check("R12 busy clear, busy error set", 64'(v[1:0]), 64'(2'b10));
    rd(S_DLO, v); check("R12 colliding write dropped", 64'(v), 64'hAAAA0001);
    wr(S_CTRL, cfg(3'd3, 1'b0, 1'b0));
    resp_en = 1'b1;

    // random streams (R3 R4 R6)
    for (int it = 0; it < 30; it++) begin
      logic [2:0] w;
      logic ai, rmode;
      logic [63:0] base, ea, d;
      int beats;
      w = 3'($urandom % 4); ai = 1'($urandom % 2); rmode = 1'($urandom % 2);
      base = {$urandom, $urandom & 32'hFFFF_FFF8};
      rdy_dly = $urandom % 4; rsp_dly = $urandom % 4;
      beats = 1 + $urandom % 3;
      ea = base;
      wr(S_CTRL, cfg(w, ai, rmode));
      wr(S_AHI, base[63:32]);
      if (!rmode) begin
        wr(S_ALO, base[31:0]);
        for (int b = 0; b < beats; b++) begin
          d = {$urandom, $urandom};
          wr(S_DHI, d[63:32]); wr(S_DLO, d[31:0]);
          wait_idle("R3 stream");
          check("R3 stream addr", h_addr, ea);
          check("R3 stream data/size", {h_wdata, 4'(h_size)}, {d, 1'b0, w});
          if (ai) ea = ea + (64'd1 << w);
        end
      end else begin
        wr(S_ALO, base[31:0]);
        wait_idle("R4 stream");
        rd(S_DLO, v); rd(S_DHI, v2);
        check("R4 stream data", {v2, v}, pat(base));
        if (ai) ea = ea + (64'd1 << w);
      end
      rd(S_ALO, v); rd(S_AHI, v2);
      check("R6 final address", {v2, v}, ea);
    end

    summary();
    $finish;
  end
endmodule